// File: doc/BRIEF.md
# Multi-Mode External Interrupt Decoder

This block takes eight active-low external interrupt pins and one active-low non-maskable pin. It turns them into a single interrupt request for a processor core. Each request carries a source kind and an 8-bit vector number. A mode input decides the role of the eight pins:

- **Dedicated:** each pin is an independent source, and each pin is set on its own to low-level or falling-edge sensing.
- **Expanded:** the eight pins together carry an inverted 8-bit vector.
- **Mixed:** the upper three pins stay dedicated. The lower five pins supply the upper five bits of a vector whose low bits are fixed at binary 010.

Every pin passes through a two-flop synchronizer before it is sampled or edge-detected. The non-maskable pin reacts to falling edges and always wins arbitration.

A small handshake state machine presents one request at a time. In state IDLE it picks the highest-priority pending source, captures it and moves to OFFER, where `req` is high. While in OFFER, a newly pending non-maskable interrupt replaces the captured request; this is the PREEMPT transition, which stays in OFFER. An `ack` in OFFER clears the captured edge flag and moves to RETIRE. RETIRE drops `req` for one cycle and returns to IDLE. Comparing the request against the current execution priority, and looking up the interrupt table, are left to the core.

Top module: `ext_irq_decoder`

## Requirements
- R1: After reset `req` is 0, `req_kind` is 0 (none) and `ded_pend` is all zero.
- R2: In dedicated mode (`mode_sel`=00; 11 behaves the same) a pin with `edge_sel` bit 0 is pending, in `ded_pend` at its own bit index, for as long as the pin is low. Its request has `req_kind`=1 and `req_vec` equal to the pin index.
- R3: A dedicated pin with `edge_sel` bit 1 latches its pending flag on a falling edge. The flag stays set after the pin rises and is cleared only by the `ack` that retires a request for that pin.
- R4: Among pending dedicated pins the highest pin index is requested first.
- R5: In expanded mode (`mode_sel`=01) `req_vec` is the bitwise inverse of the pins, with `req_kind`=2. A request is raised only if that value is nonzero, and `ded_pend` stays zero.
- R6: In mixed mode (`mode_sel`=10) pins 7:5 act as dedicated sources. `req_vec` for the vectored part is {inverse of pins 4:0, 3'b010}, raised only when the inverted pins 4:0 are nonzero. A pending dedicated source is chosen before the vector.
- R7: A falling edge on `nmi_n` produces a request with `req_kind`=3 and `req_vec`=0. This request is served before every other source, and it replaces an unacknowledged request that is already held.
- R8: A presented request keeps `req_vec` and `req_kind` stable until `ack` (except for replacement under R7). In the cycle after `ack`, `req` is 0.
- R9: If a new falling edge on an edge-sensed pin coincides with the `ack` that clears its flag, the flag stays set and the pin is requested again.
- R10: The two-flop synchronizer delays input by two edges. A level-sensed pin driven low is not requested before the third rising clock edge, and it is requested at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Pin role: 00 dedicated, 01 expanded, 10 mixed, 11 dedicated |
| edge_sel | input | 8 | Per pin: 1 falling-edge, 0 low-level sensing |
| pin_n | input | 8 | Active-low external interrupt pins |
| nmi_n | input | 1 | Active-low non-maskable interrupt pin |
| ack | input | 1 | Core acknowledge of the presented request |
| req | output | 1 | Interrupt request valid |
| req_kind | output | 2 | 0 none, 1 dedicated, 2 vectored, 3 non-maskable |
| req_vec | output | 8 | Vector number of the presented request |
| ded_pend | output | 8 | Pending flags of pins in dedicated role |

## Verification
Two events can land in the same cycle:

- **Retirement of an edge-sensed request and a fresh falling edge on the same pin.** The bench drives the pin low two cycles before pulsing `ack`, so the synchronized edge meets the clear at one clock edge. The flag must survive, and the pin must be requested again.
- **A non-maskable edge arriving while a dedicated request is held unacknowledged.** The presented kind must switch to non-maskable. After that is acknowledged, the still-low dedicated pin must be offered again.

// File: rtl/eirq_pkg.sv
`timescale 1ns/1ps
package eirq_pkg;

    typedef enum logic [1:0] {
        PINS_DEDICATED = 2'b00,
        PINS_EXPANDED  = 2'b01,
        PINS_MIXED     = 2'b10,
        PINS_ALT_DED   = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_DED  = 2'd1,
        SRC_VEC  = 2'd2,
        SRC_NMI  = 2'd3
    } src_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_OFFER  = 2'd1,
        ST_RETIRE = 2'd2
    } hs_state_e;

endpackage

// File: rtl/eirq_sync.sv
`timescale 1ns/1ps
module eirq_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // inputs are active low, so every stage resets to the inactive level
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) chain[s] <= '1;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/eirq_pend.sv
`timescale 1ns/1ps
module eirq_pend #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_s,
    input  logic [NPIN-1:0] ded_role,
    input  logic [NPIN-1:0] edge_sel,
    input  logic [NPIN-1:0] ded_clr,
    input  logic            nmi_s,
    input  logic            nmi_clr,
    output logic [NPIN-1:0] ded_pend,
    output logic            nmi_pend
);
    logic [NPIN-1:0] pin_prev;
    logic [NPIN-1:0] fall;
    logic [NPIN-1:0] armed;
    logic [NPIN-1:0] edge_flag;
    logic            nmi_prev;
    logic            nmi_fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pin_prev <= '1;
            nmi_prev <= 1'b1;
        end else begin
            pin_prev <= pin_s;
            nmi_prev <= nmi_s;
        end
    end

    assign fall     = pin_prev & ~pin_s;
    assign armed    = ded_role & edge_sel;
    assign nmi_fall = nmi_prev & ~nmi_s;

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             edge_flag[i] <= 1'b0;
            else if (!armed[i])     edge_flag[i] <= 1'b0;
            else if (fall[i])       edge_flag[i] <= 1'b1;   // a new edge outranks the clear
            else if (ded_clr[i])    edge_flag[i] <= 1'b0;
        end

        assign ded_pend[i] = ded_role[i] & (edge_sel[i] ? edge_flag[i] : ~pin_s[i]);

        // R3 / R9: a seen edge on an armed pin is latched, clear or not
        assert_edge_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (armed[i] && fall[i]) |=> edge_flag[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        nmi_pend <= 1'b0;
        else if (nmi_fall) nmi_pend <= 1'b1;
        else if (nmi_clr)  nmi_pend <= 1'b0;
    end

    assert_nmi_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_fall |=> nmi_pend);
endmodule

// File: rtl/eirq_select.sv
`timescale 1ns/1ps
module eirq_select
    import eirq_pkg::*;
#(
    parameter int NPIN    = 8,
    parameter int MIX_DED = 3,
    parameter logic [MIX_DED-1:0] MIX_FILL = 3'b010
) (
    input  pin_mode_e       mode,
    input  logic [NPIN-1:0] pin_s,
    input  logic [NPIN-1:0] ded_pend,
    input  logic            nmi_pend,
    output logic [NPIN-1:0] ded_role,
    output logic            sel_valid,
    output src_kind_e       sel_kind,
    output logic [NPIN-1:0] sel_vec
);
    localparam int PREFIX_W = NPIN - MIX_DED;

    logic [NPIN-1:0] vec_val;
    logic            vec_on;
    logic            ded_any;
    logic [NPIN-1:0] ded_idx;

    always_comb begin
        unique case (mode)
            PINS_EXPANDED: begin
                ded_role = '0;
                vec_val  = ~pin_s;
                vec_on   = |(~pin_s);
            end
            PINS_MIXED: begin
                ded_role = {{MIX_DED{1'b1}}, {PREFIX_W{1'b0}}};
                vec_val  = {~pin_s[PREFIX_W-1:0], MIX_FILL};
                vec_on   = |(~pin_s[PREFIX_W-1:0]);
            end
            default: begin
                ded_role = '1;
                vec_val  = '0;
                vec_on   = 1'b0;
            end
        endcase
    end

    // ascending scan: the last pending index seen is the highest one
    always_comb begin
        ded_any = 1'b0;
        ded_idx = '0;
        for (int i = 0; i < NPIN; i++) begin
            if (ded_pend[i]) begin
                ded_any = 1'b1;
                ded_idx = NPIN'(i);
            end
        end
    end

    always_comb begin
        sel_valid = 1'b1;
        sel_kind  = SRC_NONE;
        sel_vec   = '0;
        if (nmi_pend) begin
            sel_kind = SRC_NMI;
        end else if (ded_any) begin
            sel_kind = SRC_DED;
            sel_vec  = ded_idx;
        end else if (vec_on) begin
            sel_kind = SRC_VEC;
            sel_vec  = vec_val;
        end else begin
            sel_valid = 1'b0;
        end
    end

    always_comb begin
        if (sel_valid && sel_kind == SRC_VEC)
            assert_vec_nonzero_R5: assert (sel_vec != '0);
    end
endmodule

// File: rtl/ext_irq_decoder.sv
`timescale 1ns/1ps
module ext_irq_decoder
    import eirq_pkg::*;
#(
    parameter int NPIN        = 8,
    parameter int SYNC_STAGES = 2,
    parameter int MIX_DED     = 3,
    parameter logic [MIX_DED-1:0] MIX_FILL = 3'b010
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_sel,
    input  logic [NPIN-1:0] edge_sel,
    input  logic [NPIN-1:0] pin_n,
    input  logic            nmi_n,
    input  logic            ack,
    output logic            req,
    output logic [1:0]      req_kind,
    output logic [NPIN-1:0] req_vec,
    output logic [NPIN-1:0] ded_pend
);
    hs_state_e       st, st_nx;
    src_kind_e       cap_kind;
    logic [NPIN-1:0] cap_vec;

    logic [NPIN-1:0] pin_s;
    logic [0:0]      nmi_s;
    logic [NPIN-1:0] ded_role;
    logic [NPIN-1:0] ded_clr;
    logic            nmi_clr;
    logic            nmi_pend;
    logic            sel_valid;
    src_kind_e       sel_kind;
    logic [NPIN-1:0] sel_vec;
    logic            retire;
    logic            preempt;

    eirq_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pin_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_n), .q(pin_s)
    );

    eirq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .d(nmi_n), .q(nmi_s)
    );

    eirq_pend #(.NPIN(NPIN)) u_pend (
        .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .ded_role(ded_role),
        .edge_sel(edge_sel), .ded_clr(ded_clr), .nmi_s(nmi_s[0]),
        .nmi_clr(nmi_clr), .ded_pend(ded_pend), .nmi_pend(nmi_pend)
    );

    eirq_select #(.NPIN(NPIN), .MIX_DED(MIX_DED), .MIX_FILL(MIX_FILL)) u_select (
        .mode(pin_mode_e'(mode_sel)), .pin_s(pin_s), .ded_pend(ded_pend),
        .nmi_pend(nmi_pend), .ded_role(ded_role), .sel_valid(sel_valid),
        .sel_kind(sel_kind), .sel_vec(sel_vec)
    );

    assign retire  = (st == ST_OFFER) && ack;
    assign preempt = (st == ST_OFFER) && !ack && nmi_pend && (cap_kind != SRC_NMI);
    assign nmi_clr = retire && (cap_kind == SRC_NMI);

    for (genvar i = 0; i < NPIN; i++) begin : g_clr
        assign ded_clr[i] = retire && (cap_kind == SRC_DED) && (cap_vec == NPIN'(i));
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    // transitions: TAKE (IDLE->OFFER), PREEMPT (OFFER->OFFER), ACCEPT (OFFER->RETIRE), REARM (RETIRE->IDLE)
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (sel_valid) st_nx = ST_OFFER;
            ST_OFFER:  if (ack)       st_nx = ST_RETIRE;
            ST_RETIRE:                st_nx = ST_IDLE;
            default:                  st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_kind <= SRC_NONE;
            cap_vec  <= '0;
        end else if (st == ST_IDLE && sel_valid) begin
            cap_kind <= sel_kind;
            cap_vec  <= sel_vec;
        end else if (preempt) begin
            cap_kind <= SRC_NMI;
            cap_vec  <= '0;
        end else if (st == ST_RETIRE) begin
            cap_kind <= SRC_NONE;
            cap_vec  <= '0;
        end
    end

    // outputs
    always_comb begin
        req      = 1'b0;
        req_kind = SRC_NONE;
        req_vec  = '0;
        unique case (st)
            ST_OFFER: begin
                req      = 1'b1;
                req_kind = cap_kind;
                req_vec  = cap_vec;
            end
            ST_IDLE, ST_RETIRE: ;
            default: ;
        endcase
    end

    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !preempt) |=> (req && $stable(req_vec) && $stable(req_kind)));

    assert_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);

    assert_preempt_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && nmi_pend && req_kind != SRC_NMI) |=> (req_kind == SRC_NMI));

    assert_nmi_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && nmi_pend) |=> (req && req_kind == SRC_NMI));

    assert_clr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ded_clr));

    assert_ded_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && req_kind == SRC_DED) |-> (req_vec < NPIN));
endmodule

// File: tb/test_ext_irq_decoder.sv
`timescale 1ns/1ps
module test_ext_irq_decoder;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] mode_sel;
    logic [7:0] edge_sel;
    logic [7:0] pin_n;
    logic       nmi_n;
    logic       ack;
    logic       req;
    logic [1:0] req_kind;
    logic [7:0] req_vec;
    logic [7:0] ded_pend;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ext_irq_decoder i_ext_irq_decoder (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .edge_sel(edge_sel),
        .pin_n(pin_n), .nmi_n(nmi_n), .ack(ack), .req(req), .req_kind(req_kind),
        .req_vec(req_vec), .ded_pend(ded_pend)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int k = 0; k < 12; k++) begin
            if (req) return;
            @(negedge clk);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 req", req, 0);
        chk("R1 kind", req_kind, 0);
        chk("R1 ded_pend", ded_pend, 0);
    endtask

    task automatic t_latency();
        mode_sel = 2'b00; edge_sel = 8'h00;
        pin_n[0] = 1'b0;
        cyc(1); chk("R10 after 1 edge", req, 0);
        cyc(1); chk("R10 after 2 edges", req, 0);
        cyc(1); chk("R10 after 3 edges", req, 1);
        pin_n[0] = 1'b1; cyc(3);
        do_ack(); cyc(4);
        chk("R10 idle", req, 0);
    endtask

    task automatic t_level();
        mode_sel = 2'b00; edge_sel = 8'h00;
        pin_n[2] = 1'b0;
        wait_req();
        chk("R2 kind", req_kind, 1);
        chk("R2 vec", req_vec, 2);
        chk("R2 pend", ded_pend, 8'h04);
        do_ack();
        chk("R8 gap after ack", req, 0);
        wait_req();
        chk("R2 level repeats", {req, req_kind, req_vec}, {1'b1, 2'd1, 8'd2});
        pin_n[2] = 1'b1; cyc(4);
        chk("R2 pend drops", ded_pend, 0);
        chk("R8 held until ack", {req, req_vec}, {1'b1, 8'd2});
        do_ack(); cyc(5);
        chk("R2 idle", req, 0);
    endtask

    task automatic t_edge();
        mode_sel = 2'b00; edge_sel = 8'h10;
        pin_n[4] = 1'b0; cyc(1); pin_n[4] = 1'b1;
        wait_req();
        chk("R3 req", {req, req_kind, req_vec}, {1'b1, 2'd1, 8'd4});
        cyc(3);
        chk("R3 latched after rise", ded_pend, 8'h10);
        do_ack(); cyc(1);
        chk("R3 cleared by ack", ded_pend, 0);
        cyc(4);
        chk("R3 no rerequest", req, 0);
    endtask

    task automatic t_priority();
        mode_sel = 2'b11; edge_sel = 8'h00;
        pin_n[1] = 1'b0; pin_n[6] = 1'b0;
        wait_req();
        chk("R4 highest first", req_vec, 6);
        pin_n[6] = 1'b1; cyc(3);
        do_ack();
        wait_req();
        chk("R4 next lower", {req_kind, req_vec}, {2'd1, 8'd1});
        pin_n[1] = 1'b1; cyc(4);
        do_ack(); cyc(5);
        chk("R4 idle", req, 0);
    endtask

    task automatic t_expanded();
        mode_sel = 2'b01; edge_sel = 8'hFF;
        pin_n = 8'hA5;
        wait_req();
        chk("R5 kind", req_kind, 2);
        chk("R5 vec inverted", req_vec, 8'h5A);
        chk("R5 no dedicated", ded_pend, 0);
        pin_n = 8'hFF; cyc(3);
        do_ack(); cyc(5);
        chk("R5 zero vector no request", req, 0);
    endtask

    task automatic t_mixed();
        mode_sel = 2'b10; edge_sel = 8'h00;
        pin_n = 8'hEC;   // pins 7:5 high, pins 4:0 = 01100
        wait_req();
        chk("R6 vec fill", {req_kind, req_vec}, {2'd2, 8'h9A});
        chk("R6 no dedicated", ded_pend, 0);
        pin_n[5] = 1'b0; cyc(3);
        do_ack();
        wait_req();
        chk("R6 dedicated beats vector", {req_kind, req_vec}, {2'd1, 8'd5});
        chk("R6 pend bit5", ded_pend, 8'h20);
        pin_n = 8'hFF; cyc(4);
        do_ack(); cyc(5);
        chk("R6 idle", req, 0);
    endtask

    task automatic t_nmi();
        mode_sel = 2'b00; edge_sel = 8'h00;
        pin_n[3] = 1'b0;
        wait_req();
        chk("R7 base request", req_vec, 3);
        nmi_n = 1'b0; cyc(1); nmi_n = 1'b1;
        cyc(6);
        chk("R7 preempted", {req, req_kind, req_vec}, {1'b1, 2'd3, 8'd0});
        do_ack();
        wait_req();
        chk("R7 dedicated returns", {req_kind, req_vec}, {2'd1, 8'd3});
        pin_n[3] = 1'b1; cyc(4);
        do_ack(); cyc(5);
        chk("R7 idle", req, 0);
    endtask

    task automatic t_collide();
        mode_sel = 2'b00; edge_sel = 8'h80;
        pin_n[7] = 1'b0; cyc(1); pin_n[7] = 1'b1;
        wait_req();
        chk("R9 first", req_vec, 7);
        cyc(2);
        pin_n[7] = 1'b0;       // synchronized edge lands two edges later
        cyc(2);
        ack = 1'b1;            // sampled at the edge that latches the new fall
        @(negedge clk);
        ack = 1'b0;
        pin_n[7] = 1'b1;
        chk("R9 flag survives", ded_pend, 8'h80);
        wait_req();
        chk("R9 requested again", {req_kind, req_vec}, {2'd1, 8'd7});
        do_ack(); cyc(1);
        chk("R9 finally clear", ded_pend, 0);
        cyc(4);
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 2'b00; edge_sel = 8'h00;
        pin_n = 8'hFF; nmi_n = 1'b1; ack = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_latency();
        t_level();
        t_edge();
        t_priority();
        t_expanded();
        t_mixed();
        t_nmi();
        t_collide();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule